// File: doc/BRIEF.md
# Strobe-Driven FIFO with Retransmit

This block is a first-in first-out buffer for 9-bit words. A producer and a consumer reach it through active-low write and read strobes instead of clock enables. Both strobes are sampled on the system clock, and their edges are found inside the block. A write commits its word when the write strobe returns high. A read presents the oldest word for as long as the read strobe is held low, and the word is consumed when that strobe returns high.

Three active-low status flags show the buffer level: empty, full, and more than half full. Overrun and underrun are blocked at the strobe edge, so a rejected strobe leaves no trace. A low level on the retransmit input rewinds the read side to physical location 0. This lets a packet that has not been acknowledged be sent again, and all flags are recomputed from the rewound pointers. In place of a three-state output bus there is an output-enable signal, and the data bus reads zero whenever it is disabled. The depth is a parameter and must be a power of two.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst` is high, and at every clock after it, the flags hold their empty state: `empty_n`=0, `full_n`=1, `half_n`=1 and `dout_oe`=0. A read strobe pulsed on the freshly reset buffer leaves `dout_oe` at 0.
- R2: On the rising edge of `wr_n`, the word on `din` is stored in the next sequential location. Reads return the words in the order they were written.
- R3: A write strobe whose falling edge finds the buffer full is ignored. Its word never appears at the output, and the write pointer does not advance.
- R4: A read strobe whose falling edge finds the buffer empty is ignored. `dout_oe` stays 0, the read pointer does not advance, and the next word written is the next word read.
- R5: `empty_n` goes high one clock after the rising edge of the first write into an empty buffer. It goes low one clock after the falling edge of the read strobe that takes the last word.
- R6: `full_n` goes low one clock after the falling edge of the write that takes the last free location. It goes high one clock after the rising edge of a read taken from a full buffer.
- R7: `half_n` goes low one clock after a write falling edge that brings occupancy to DEPTH/2+1. It goes high one clock after the read rising edge that brings occupancy from DEPTH/2+1 down to DEPTH/2.
- R8: While `rt_n` is low, the read pointer is set to location 0, and the flags follow the new pointer difference on the next clock. The reads that follow replay the words from the first one written since reset, then continue with words written afterwards. This holds only when at most DEPTH writes have taken place since reset.
- R9: `dout_oe` is 1 only while `rd_n` is low during an accepted read. While `dout_oe` is 0, `dout` reads 0.
- R10: A strobe that is already low when reset releases is ignored, and so is a strobe that falls while `rt_n` is low. Neither stores nor removes a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst | input | 1 | Synchronous active-high master reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low retransmit (read rewind) |
| din | input | 9 | Write data, captured on the rising edge of `wr_n` |
| dout | output | 9 | Read data; zero while disabled |
| dout_oe | output | 1 | High while `dout` carries a valid word |
| empty_n | output | 1 | Low when no word can be read |
| full_n | output | 1 | Low when no location can be written |
| half_n | output | 1 | Low when occupancy exceeds DEPTH/2 |

## Verification
Every flag is a pure function of the two pointers and the two in-progress strobes. A corrupted pointer therefore shows up at the ports on the next clock, as a wrong flag level or a wrong word on `dout` during the next accepted read. A strobe tracker stuck in the armed state would show as a skipped or duplicated word at the next read of the affected location. The retransmit scenarios replay complete word sequences and check the flags right after the rewind, so a rewind to the wrong location or a stale occupancy shows within one read.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    localparam int WORD_W = 9;
    localparam int N_CH   = 2;
    localparam int CH_WR  = 0;
    localparam int CH_RD  = 1;

    typedef logic [WORD_W-1:0] word_t;

    // status flags, all active low
    typedef struct packed {
        logic empty_n;
        logic half_n;
        logic full_n;
    } flags_t;

    // per-strobe events produced by the edge tracker
    typedef struct packed {
        logic start;   // accepted falling edge
        logic finish;  // rising edge closing an accepted access
        logic armed;   // access in progress
    } strobe_evt_t;

    function automatic int half_mark(input int depth);
        return depth / 2;
    endfunction

endpackage

// File: rtl/strobe_track.sv
module strobe_track
    import strobe_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe_n,
    input  logic        allow,
    input  logic        hold,
    output strobe_evt_t evt
);

    logic prev_q;
    logic armed_q;
    logic fall;
    logic rise;

    // prev_q clears to 0 so a strobe held low across reset never shows a fall
    assign fall = prev_q & ~strobe_n;
    assign rise = ~prev_q & strobe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            prev_q <= strobe_n;
            if (hold)
                armed_q <= 1'b0;
            else if (fall && allow)
                armed_q <= 1'b1;
            else if (rise)
                armed_q <= 1'b0;
        end
    end

    always_comb begin
        evt.start  = fall & allow & ~hold;
        evt.finish = rise & armed_q & ~hold;
        evt.armed  = armed_q;
    end

endmodule

// File: rtl/fifo_ram.sv
module fifo_ram
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fifo_ptrs.sv
module fifo_ptrs
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rewind,
    input  strobe_evt_t   wr_evt,
    input  strobe_evt_t   rd_evt,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output logic          can_write,
    output logic          can_read,
    output flags_t        flags
);

    localparam logic [PW-1:0] FULL_OCC = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_OCC = PW'(half_mark(DEPTH));

    logic [PW-1:0] occ;
    logic [PW-1:0] wr_view;
    logic [PW-1:0] rd_view;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_evt.finish)
                wptr <= wptr + 1'b1;
            if (rewind)
                rptr <= '0;
            else if (rd_evt.finish)
                rptr <= rptr + 1'b1;
        end
    end

    // committed occupancy; the writer's view adds its pending word,
    // the reader's view removes the word being read
    assign occ     = wptr - rptr;
    assign wr_view = occ + PW'(wr_evt.armed);
    assign rd_view = occ - PW'(rd_evt.armed);

    assign can_write = (occ != FULL_OCC);
    assign can_read  = (occ != '0);

    always_comb begin
        flags.empty_n = (rd_view != '0);
        flags.full_n  = (wr_view != FULL_OCC);
        flags.half_n  = !(wr_view > HALF_OCC);
    end

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_n,
    input  logic        rd_n,
    input  logic        rt_n,
    input  logic [8:0]  din,
    output logic [8:0]  dout,
    output logic        dout_oe,
    output logic        empty_n,
    output logic        full_n,
    output logic        half_n
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          rewind;
    logic [N_CH-1:0] stb_n;
    logic [N_CH-1:0] allow;
    strobe_evt_t   evt [N_CH];
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic          can_write;
    logic          can_read;
    flags_t        flags;
    word_t         rdata;

    assign rewind = ~rt_n;

    assign stb_n[CH_WR] = wr_n;
    assign stb_n[CH_RD] = rd_n;
    assign allow[CH_WR] = can_write;
    assign allow[CH_RD] = can_read;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_strobe
        strobe_track u_track (
            .clk      (clk),
            .rst      (rst),
            .strobe_n (stb_n[ch]),
            .allow    (allow[ch]),
            .hold     (rewind),
            .evt      (evt[ch])
        );
    end

    fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk       (clk),
        .rst       (rst),
        .rewind    (rewind),
        .wr_evt    (evt[CH_WR]),
        .rd_evt    (evt[CH_RD]),
        .wptr      (wptr),
        .rptr      (rptr),
        .can_write (can_write),
        .can_read  (can_read),
        .flags     (flags)
    );

    fifo_ram #(.DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (evt[CH_WR].finish),
        .waddr (wptr[AW-1:0]),
        .wdata (din),
        .raddr (rptr[AW-1:0]),
        .rdata (rdata)
    );

    assign dout_oe = evt[CH_RD].armed & ~rd_n;
    assign dout    = dout_oe ? rdata : '0;
    assign empty_n = flags.empty_n;
    assign full_n  = flags.full_n;
    assign half_n  = flags.half_n;

endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int PW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_n,
    input logic          rt_n,
    input logic          wr_n,
    input logic          dout_oe,
    input logic          empty_n,
    input logic          full_n,
    input logic          half_n,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr
);

    // R1: reset leaves the empty state on the flags
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!empty_n && full_n && half_n && !dout_oe));

    // R3: committed occupancy never exceeds the depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        ((wptr - rptr) <= PW'(DEPTH)));

    // R2: the write pointer moves by at most one per clock
    a_r2_wptr_step: assert property (@(posedge clk) disable iff (rst)
        (wptr == $past(wptr)) || (wptr == $past(wptr) + 1'b1));

    // R6: a full buffer is also more than half full
    a_r6_full_over_half: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> !half_n);

    // R5: empty and full are never both active
    a_r5_empty_not_full: assert property (@(posedge clk) disable iff (rst)
        !empty_n |-> full_n);

    // R9: output enabled only while the read strobe is low
    a_r9_oe_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> !rd_n);

    // R8: retransmit rewinds the read pointer to location 0
    a_r8_rewind: assert property (@(posedge clk) disable iff (rst)
        !rt_n |=> (rptr == '0));

    // R10: no write pointer movement while retransmit is held
    a_r10_hold_writes: assert property (@(posedge clk) disable iff (rst)
        (!rt_n && !$past(rst)) |=> (wptr == $past(wptr)) || $past(wr_n) == 1'b0);

endmodule

bind strobe_fifo strobe_fifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_n    (rd_n),
    .rt_n    (rt_n),
    .wr_n    (wr_n),
    .dout_oe (dout_oe),
    .empty_n (empty_n),
    .full_n  (full_n),
    .half_n  (half_n),
    .wptr    (wptr),
    .rptr    (rptr)
);

// File: tb/test_strobe_fifo.sv
module test_strobe_fifo;

    localparam int DEPTH = 16;
    localparam int HALF  = DEPTH / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       rt_n = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       dout_oe;
    logic       empty_n;
    logic       full_n;
    logic       half_n;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    strobe_fifo #(.DEPTH(DEPTH)) i_strobe_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .rt_n    (rt_n),
        .din     (din),
        .dout    (dout),
        .dout_oe (dout_oe),
        .empty_n (empty_n),
        .full_n  (full_n),
        .half_n  (half_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_miss++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // every task starts and ends at a falling clock edge
    task automatic step();
        @(negedge clk);
    endtask
    task automatic wr_lo(input logic [8:0] d);
        wr_n = 1'b0; din = d; step();
    endtask
    task automatic wr_hi();
        wr_n = 1'b1; step();
    endtask
    task automatic rd_lo();
        rd_n = 1'b0; step();
    endtask
    task automatic rd_hi();
        rd_n = 1'b1; step();
    endtask
    task automatic put(input logic [8:0] d);
        wr_lo(d); wr_hi();
    endtask
    task automatic get(input string req, input logic [8:0] exp);
        rd_lo();
        chk({req, " oe"}, int'(dout_oe), 1);
        chk({req, " data"}, int'(dout), int'(exp));
        rd_hi();
    endtask
    task automatic do_reset();
        rst = 1'b1; step(); step(); rst = 1'b0; step();
    endtask
    task automatic rewind();
        rt_n = 1'b0; step(); rt_n = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1; step();
        chk("R1 empty_n in reset", int'(empty_n), 0);
        step(); rst = 1'b0; step();
        chk("R1 empty_n", int'(empty_n), 0);
        chk("R1 full_n", int'(full_n), 1);
        chk("R1 half_n", int'(half_n), 1);
        chk("R1 dout_oe", int'(dout_oe), 0);
        rd_lo();
        chk("R1 oe after read attempt", int'(dout_oe), 0);
        rd_hi();
    endtask

    task automatic t_order();
        do_reset();
        wr_lo(9'h0A5);
        chk("R5 still empty before write rise", int'(empty_n), 0);
        wr_hi();
        chk("R5 empty_n after first write rise", int'(empty_n), 1);
        put(9'h13C); put(9'h000);
        get("R2 word0", 9'h0A5);
        get("R2 word1", 9'h13C);
        rd_lo();
        chk("R5 empty_n at last read fall", int'(empty_n), 0);
        chk("R9 oe during last read", int'(dout_oe), 1);
        chk("R2 word2", int'(dout), 0);
        rd_hi();
        chk("R9 oe off after read", int'(dout_oe), 0);
        chk("R9 dout zero when disabled", int'(dout), 0);
    endtask

    task automatic t_underrun();
        do_reset();
        rd_lo();
        chk("R4 oe on empty read", int'(dout_oe), 0);
        chk("R4 dout on empty read", int'(dout), 0);
        rd_hi();
        put(9'h155);
        get("R4 next word after ignored read", 9'h155);
        chk("R4 empty again", int'(empty_n), 0);
    endtask

    task automatic t_fill();
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            wr_lo(9'(i * 7 + 3));
            if (i == HALF - 1) chk("R7 half_n at half", int'(half_n), 1);
            if (i == HALF)     chk("R7 half_n at half+1", int'(half_n), 0);
            if (i == DEPTH - 2) chk("R6 full_n one short", int'(full_n), 1);
            if (i == DEPTH - 1) chk("R6 full_n at last write fall", int'(full_n), 0);
            wr_hi();
        end
        wr_lo(9'h1FF);
        chk("R3 full_n during rejected write", int'(full_n), 0);
        wr_hi();
        for (int j = 0; j < DEPTH; j++) begin
            rd_lo();
            chk("R3 data after overrun", int'(dout), (j * 7 + 3) & 9'h1FF);
            if (j == 0) chk("R6 full_n at read fall", int'(full_n), 0);
            if (j == DEPTH - HALF - 1) chk("R7 half_n at read fall", int'(half_n), 0);
            rd_hi();
            if (j == 0) chk("R6 full_n after read rise", int'(full_n), 1);
            if (j == DEPTH - HALF - 1) chk("R7 half_n after read rise", int'(half_n), 1);
        end
        chk("R3 empty after depth reads", int'(empty_n), 0);
        rd_lo();
        chk("R3 rejected word absent", int'(dout_oe), 0);
        rd_hi();
    endtask

    task automatic t_retransmit();
        do_reset();
        for (int i = 0; i < 5; i++) put(9'(9'h040 + i));
        for (int i = 0; i < 5; i++) get("R8 first pass", 9'(9'h040 + i));
        chk("R8 empty before rewind", int'(empty_n), 0);
        rewind();
        step();
        chk("R8 empty_n after rewind", int'(empty_n), 1);
        chk("R8 half_n after rewind", int'(half_n), 1);
        for (int i = 0; i < 5; i++) get("R8 replay", 9'(9'h040 + i));
        put(9'h0EE);
        get("R8 word after rewind", 9'h0EE);
        // occupancy above half after rewind
        for (int i = 0; i < 4; i++) put(9'(9'h080 + i));
        for (int i = 0; i < 4; i++) get("R8 drain", 9'(9'h080 + i));
        rewind();
        step();
        chk("R8 half_n recomputed", int'(half_n), 0);
        chk("R8 full_n recomputed", int'(full_n), 1);
        for (int i = 0; i < 5; i++) get("R8 second replay", 9'(9'h040 + i));
        get("R8 second replay tail", 9'h0EE);
    endtask

    task automatic t_ignored();
        rst = 1'b1; wr_n = 1'b0; din = 9'h0AA; step(); step();
        rst = 1'b0; step();
        wr_hi();
        chk("R10 strobe low across reset", int'(empty_n), 0);
        rt_n = 1'b0; step();
        wr_lo(9'h0BB);
        rt_n = 1'b1; step();
        wr_hi();
        chk("R10 strobe under retransmit", int'(empty_n), 0);
        rd_lo();
        chk("R10 nothing to read", int'(dout_oe), 0);
        rd_hi();
        put(9'h0CC);
        get("R10 next real word", 9'h0CC);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin : main
        step();
        t_reset();
        t_order();
        t_underrun();
        t_fill();
        t_retransmit();
        t_ignored();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule